// File: doc/BRIEF.md
# Segmented Iterative Adder with Early Completion

This block adds two unsigned operands over several clock cycles. The operand width is cut into equal segments. Each segment holds a flat, two-level carry network over its own bits. Each segment reads, as its incoming carry, the registered top carry of the segment beneath it. All segments evaluate in parallel in every round. A carry that has to cross a segment boundary therefore moves up by one segment per clock. The block keeps iterating until the vector of segment carries no longer changes, and then raises `done`.

A `start` pulse latches both operands. The first cycle after `start` is a seed cycle: every segment evaluates with its incoming carry assumed to be zero. Each later cycle is a propagation round, and the round counter records only the rounds that changed a carry.

A small predictor looks at the operands when `start` arrives. It looks for runs of segments in which every bit position has unequal operand bits. Short runs prove that one or two propagation rounds are enough. In that case the block finishes as soon as that many rounds have run, and skips the confirming round that would show the carries are stable. Result, flag and count stay frozen until the next `start`.

Top module: `seg_iter_adder`

## Requirements
- R1: While `done_o` is high, `sum_o` equals the unsigned sum of the operands latched at the last start, WIDTH+1 bits wide, with the carry out of the top bit in bit WIDTH.
- R2: After reset, and in the cycle after any start pulse, `done_o` is low and `rounds_o` is zero. Operands are sampled only in the cycle where `start_i` is high.
- R3: Once `done_o` is high, it stays high and `sum_o` does not change until the next start. Changes on `x_i`/`y_i` without a start have no effect on either.
- R4: A segment "fully differs" when x XOR y is all ones across its SEG bits. At completion, `rounds_o` equals the longest run of adjacent fully-differing segments above segment 0 whose true incoming carry is 1, or zero if there is no such run.
- R5: `rounds_o` never exceeds NSEG-1, and it grows by at most one per cycle.
- R6: Without a prediction, `done_o` rises L+2 clock edges after the start edge, where L is the R4 count: one seed cycle, L changing rounds and one confirming round.
- R7: If no two adjacent segments above segment 0 fully differ, the one-round prediction applies. `done_o` rises by edge 2 after start, exactly at edge 2 when L is 1, and `rounds_o` is at most 1.
- R8: If R7 fails but no three adjacent segments above segment 0 fully differ, the two-round prediction applies. `done_o` rises by edge 3 after start, exactly at edge 3 when L is 2, and `rounds_o` is at most 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Latch operands and begin a new addition |
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH+1 | Sum including carry out |
| done_o | output | 1 | Result valid, held until next start |
| rounds_o | output | $clog2(NSEG)+1 | Number of carry-changing propagation rounds |

## Verification
The bench builds the block with its defaults: 32-bit operands in 4-bit segments, which gives eight segments. With these values a carry can ripple across seven fully differing segments, so the worst case of R5 can be reached with a single operand pair. They also allow runs of length one, two and three to be placed on purpose, which drives each completion path separately: the one-round prediction, the two-round prediction and the confirming round. The same geometry lets a scrambled sweep hit every run length, with the bench computing the expected count and latency from the segment pattern alone.

// File: rtl/seg_iter_adder_pkg.sv
package seg_iter_adder_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEED = 2'd1,
      PH_ITER = 2'd2
   } phase_e;

   // Encoded early-completion bound: 0 = none, 1 or 2 = guaranteed round limit
   typedef logic [1:0] bound_t;

endpackage

// File: rtl/seg_iter_adder_seg.sv
module seg_iter_adder_seg #(
   parameter int SEG = 4
) (
   input  logic [SEG-1:0] a_i,
   input  logic [SEG-1:0] b_i,
   input  logic           cin_i,
   output logic [SEG-1:0] sum_o,
   output logic           cout_o
);

   logic [SEG-1:0] gen_w;
   logic [SEG-1:0] pass_w;
   logic [SEG-1:0] cy_w;
   logic [SEG-1:0] cbit_w;

   assign gen_w  = a_i & b_i;
   assign pass_w = a_i | b_i;

   // Two-level carry out of bit pos: OR of every generate term gated by the
   // pass terms above it, plus the incoming carry gated by all pass terms.
   function automatic logic flat_carry(input logic [SEG-1:0] g,
                                       input logic [SEG-1:0] p,
                                       input logic c,
                                       input int pos);
      logic acc;
      logic term;
      acc  = 1'b0;
      term = c;
      for (int k = 0; k <= pos; k++) term = term & p[k];
      acc = term;
      for (int j = 0; j <= pos; j++) begin
         term = g[j];
         for (int k = j + 1; k <= pos; k++) term = term & p[k];
         acc = acc | term;
      end
      return acc;
   endfunction

   for (genvar i = 0; i < SEG; i++) begin : g_bit
      assign cy_w[i] = flat_carry(gen_w, pass_w, cin_i, i);
   end

   assign cbit_w = {cy_w[SEG-2:0], cin_i};
   assign sum_o  = a_i ^ b_i ^ cbit_w;
   assign cout_o = cy_w[SEG-1];

endmodule

// File: rtl/seg_iter_adder_pred.sv
module seg_iter_adder_pred
   import seg_iter_adder_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SEG   = 4,
   localparam int NSEG = WIDTH / SEG
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output bound_t           bound_o
);

   logic [WIDTH-1:0] diff_w;
   logic [NSEG-1:0]  full_w;
   logic             one_ok;
   logic             two_ok;

   assign diff_w = a_i ^ b_i;

   // Segment 0 always sees a known zero carry, so it never extends a run.
   for (genvar k = 0; k < NSEG; k++) begin : g_full
      if (k == 0) begin : g_base
         assign full_w[k] = 1'b0;
      end else begin : g_upper
         assign full_w[k] = &diff_w[k*SEG +: SEG];
      end
   end

   assign one_ok = ~|(full_w[NSEG-1:1] & full_w[NSEG-2:0]);
   assign two_ok = ~|(full_w[NSEG-1:2] & full_w[NSEG-2:1] & full_w[NSEG-3:0]);

   assign bound_o = one_ok ? bound_t'(1) : (two_ok ? bound_t'(2) : bound_t'(0));

endmodule

// File: rtl/seg_iter_adder.sv
module seg_iter_adder
   import seg_iter_adder_pkg::*;
#(
   parameter int  WIDTH = 32,
   parameter int  SEG   = 4,
   localparam int NSEG  = WIDTH / SEG,
   localparam int RW    = $clog2(NSEG) + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   output logic [WIDTH:0]   sum_o,
   output logic             done_o,
   output logic [RW-1:0]    rounds_o
);

   if (SEG < 2) begin : g_chk_seg
      $error("SEG must be at least 2");
   end
   if (WIDTH % SEG != 0) begin : g_chk_div
      $error("WIDTH must be a multiple of SEG");
   end
   if (NSEG < 3) begin : g_chk_nseg
      $error("at least three segments are required");
   end

   logic [WIDTH-1:0] xq, yq;
   logic [NSEG-1:0]  c_q;
   logic [NSEG-1:0]  nxt_c;
   logic [NSEG-1:0]  cin_v;
   logic [WIDTH-1:0] sum_w;
   logic [RW-1:0]    rnd_q;
   logic [RW-1:0]    rnd_inc;
   logic             done_q;
   bound_t           bound_q;
   bound_t           bound_w;
   phase_e           ph_q;

   assign cin_v   = {c_q[NSEG-2:0], 1'b0};
   assign rnd_inc = rnd_q + RW'(1);

   for (genvar k = 0; k < NSEG; k++) begin : g_seg
      seg_iter_adder_seg #(.SEG(SEG)) u_seg (
         .a_i   (xq[k*SEG +: SEG]),
         .b_i   (yq[k*SEG +: SEG]),
         .cin_i (cin_v[k]),
         .sum_o (sum_w[k*SEG +: SEG]),
         .cout_o(nxt_c[k])
      );
   end

   seg_iter_adder_pred #(.WIDTH(WIDTH), .SEG(SEG)) u_pred (
      .a_i    (x_i),
      .b_i    (y_i),
      .bound_o(bound_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         xq      <= '0;
         yq      <= '0;
         c_q     <= '0;
         rnd_q   <= '0;
         done_q  <= 1'b0;
         bound_q <= '0;
         ph_q    <= PH_IDLE;
      end else if (start_i) begin
         xq      <= x_i;
         yq      <= y_i;
         c_q     <= '0;
         rnd_q   <= '0;
         done_q  <= 1'b0;
         bound_q <= bound_w;
         ph_q    <= PH_SEED;
      end else begin
         case (ph_q)
            PH_SEED: begin
               c_q  <= nxt_c;
               ph_q <= PH_ITER;
            end
            PH_ITER: begin
               if (nxt_c == c_q) begin
                  done_q <= 1'b1;
                  ph_q   <= PH_IDLE;
               end else begin
                  c_q   <= nxt_c;
                  rnd_q <= rnd_inc;
                  if (bound_q != '0 && rnd_inc == RW'(bound_q)) begin
                     done_q <= 1'b1;
                     ph_q   <= PH_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sum_o    = {c_q[NSEG-1], sum_w};
   assign done_o   = done_q;
   assign rounds_o = rnd_q;

endmodule

// File: rtl/seg_iter_adder_chk.sv
module seg_iter_adder_chk #(
   parameter int  WIDTH = 32,
   parameter int  SEG   = 4,
   localparam int NSEG  = WIDTH / SEG,
   localparam int RW    = $clog2(NSEG) + 1
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           start_i,
   input logic           done_o,
   input logic [WIDTH:0] sum_o,
   input logic [RW-1:0]  rounds_o,
   input logic [1:0]     bound_q
);

   a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (!done_o && rounds_o == '0));

   a_r3_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> done_o);

   a_r3_sum_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> $stable(sum_o));

   a_r5_round_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (rounds_o == $past(rounds_o) || rounds_o == $past(rounds_o) + RW'(1)));

   a_r5_rounds_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rounds_o <= RW'(NSEG - 1));

   // R7 and R8: a predicted bound is never exceeded
   a_r7_bound_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && bound_q != 2'd0) |-> rounds_o <= RW'(bound_q));

endmodule

bind seg_iter_adder seg_iter_adder_chk #(.WIDTH(WIDTH), .SEG(SEG)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .done_o  (done_o),
   .sum_o   (sum_o),
   .rounds_o(rounds_o),
   .bound_q (bound_q)
);

// File: tb/seg_iter_adder_bench.sv
`timescale 1ns/1ps
module seg_iter_adder_bench;

   localparam int W   = 32;
   localparam int S   = 4;
   localparam int N   = W / S;
   localparam int RWB = $clog2(N) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  x = '0;
   logic [W-1:0]  y = '0;
   logic [W:0]    sum;
   logic          done;
   logic [RWB-1:0] rounds;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   seg_iter_adder #(.WIDTH(W), .SEG(S)) u_seg_iter_adder (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .x_i(x), .y_i(y), .sum_o(sum), .done_o(done), .rounds_o(rounds)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int model_rounds(input logic [W-1:0] a, input logic [W-1:0] b);
      int run;
      int best;
      logic [W:0] lo;
      logic [W:0] msk;
      logic cin;
      logic full;
      run = 0;
      best = 0;
      for (int k = 1; k < N; k++) begin
         msk  = (({{W{1'b0}}, 1'b1}) << (k*S)) - 1;
         lo   = ({1'b0, a} & msk) + ({1'b0, b} & msk);
         cin  = lo[k*S];
         full = &((a ^ b) >> (k*S)) | (((a ^ b) >> (k*S)) & S'('1)) == S'('1);
         full = ((((a ^ b) >> (k*S)) & W'(2**S - 1)) == W'(2**S - 1));
         if (full) run = (run > 0) ? run + 1 : (cin ? 1 : 0);
         else      run = 0;
         if (run > best) best = run;
      end
      return best;
   endfunction

   function automatic int model_bound(input logic [W-1:0] a, input logic [W-1:0] b);
      bit fl [N];
      bit one;
      bit two;
      one = 1;
      two = 1;
      for (int k = 0; k < N; k++)
         fl[k] = (k > 0) && ((((a ^ b) >> (k*S)) & W'(2**S - 1)) == W'(2**S - 1));
      for (int k = 1; k < N; k++) if (fl[k] && fl[k-1]) one = 0;
      for (int k = 2; k < N; k++) if (fl[k] && fl[k-1] && fl[k-2]) two = 0;
      return one ? 1 : (two ? 2 : 0);
   endfunction

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
      int exp_r;
      int exp_b;
      int exp_lat;
      int lat;
      string lt;
      exp_r   = model_rounds(a, b);
      exp_b   = model_bound(a, b);
      exp_lat = (exp_b != 0 && exp_r == exp_b) ? 1 + exp_b : exp_r + 2;
      lt      = (exp_b == 1) ? "R7" : ((exp_b == 2) ? "R8" : "R6");
      @(negedge clk);
      x = a; y = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && rounds == '0, "R2", "state after start", {done, 4'h0, rounds}, 0);
      lat = 0;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(sum == {1'b0, a} + {1'b0, b}, "R1", "sum", sum, {1'b0, a} + {1'b0, b});
      chk(int'(rounds) == exp_r, "R4", "rounds", rounds, exp_r);
      chk(int'(rounds) <= N - 1, "R5", "rounds cap", rounds, N - 1);
      chk(lat == exp_lat, lt, "completion latency", lat, exp_lat);
   endtask

   task automatic t_reset();
      chk(!done, "R2", "done after reset", done, 0);
      chk(rounds == '0, "R2", "rounds after reset", rounds, 0);
      chk(sum == '0, "R2", "sum after reset", sum, 0);
   endtask

   // Three-segment chain, no prediction: rounds 3, latency 5
   task automatic t_chain3();
      logic [W-1:0] a, b;
      a = 32'b1010_1101_0011_0111_1001_0000_0110_1001;
      b = 32'b1101_1000_1100_1001_0110_1111_1001_1100;
      run_op(a, b);
      chk(sum == 33'b1_1000_0110_0000_0001_0000_0000_0000_0101, "R1", "chain3 sum",
          sum, 33'b1_1000_0110_0000_0001_0000_0000_0000_0101);
      chk(rounds == RWB'(3), "R4", "chain3 rounds", rounds, 3);
   endtask

   task automatic t_one_round();
      run_op(32'b1010_1101_0011_0111_1001_0001_0110_1001,
             32'b1101_1000_1100_1001_0110_1111_1001_1100);
      chk(rounds == RWB'(1), "R7", "one-round count", rounds, 1);
   endtask

   task automatic t_two_round();
      run_op(32'b1010_1101_0011_0111_1000_0000_0110_1001,
             32'b1101_1000_1100_1001_0110_1111_1001_1100);
      chk(rounds == RWB'(2), "R8", "two-round count", rounds, 2);
   endtask

   task automatic t_zero();
      run_op('0, '0);
      chk(rounds == '0, "R6", "zero operands rounds", rounds, 0);
   endtask

   task automatic t_worst();
      run_op(32'hFFFF_FFFF, 32'h0000_0001);
      chk(rounds == RWB'(N - 1), "R5", "worst chain rounds", rounds, N - 1);
      chk(sum == 33'h1_0000_0000, "R1", "worst chain sum", sum, 33'h1_0000_0000);
   endtask

   task automatic t_hold();
      logic [W:0] held;
      run_op(32'h8765_4321, 32'h9ABC_DEF0);
      held = sum;
      @(negedge clk);
      x = 32'h1111_1111; y = 32'hEEEE_EEEF;
      repeat (5) @(negedge clk);
      chk(done, "R3", "done held", done, 1);
      chk(sum == held, "R3", "sum held with input change", sum, held);
   endtask

   task automatic t_sweep();
      logic [W-1:0] r1, r2;
      r1 = 32'h1234_5678;
      r2 = 32'hCAFE_0001;
      for (int i = 0; i < 300; i++) begin
         r1 = r1 ^ (r1 << 13); r1 = r1 ^ (r1 >> 17); r1 = r1 ^ (r1 << 5);
         r2 = r2 ^ (r2 << 7);  r2 = r2 ^ (r2 >> 9);  r2 = r2 ^ (r2 << 8);
         if (i % 3 == 0) run_op(r1, ~r1 ^ (r2 & 32'h0101_0011));
         else            run_op(r1, r2);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chain3();
      t_one_round();
      t_two_round();
      t_zero();
      t_worst();
      t_hold();
      t_sweep();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule